// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a two-part logical address, a segment number plus an offset inside that segment, into a flat physical address. It keeps a small table of segment descriptors in internal registers. This table stands in for a cached copy of a table held in memory. Each descriptor holds a starting physical address (base), a segment length (limit), a valid flag and three access-right bits for read, write and execute. A separate register holds how many segments are currently in use.

Each request is checked in turn. The segment number must be below the in-use count, the descriptor must be valid, the offset must be below the limit, and the requested kind of access must be allowed. If all checks succeed, the unit returns base plus offset. If a check fails, it returns a trap code for the first check that failed. Software-side logic loads descriptors through an index/data write port and sets the in-use count through its own write strobe. The result is registered and appears one clock after the request.

Top module: `seg_xlate`

## Requirements
- R1: After reset all outputs are zero, every descriptor is invalid and the in-use count is zero, so the first translation after reset traps with code 1.
- R2: A request sampled with `req_vld` high at a rising edge produces its result on the outputs after that edge, with `rsp_vld` high. A cycle without a request gives `rsp_vld`, `rsp_ok`, `rsp_pa` and `rsp_trap` all zero.
- R3: A segment number greater than or equal to the in-use count gives trap code 1.
- R4: A segment in range whose descriptor has its valid flag clear gives trap code 2.
- R5: An offset greater than or equal to the descriptor limit gives trap code 3. An offset of limit minus one passes this check.
- R6: Access kind 0 is read, 1 is write and 2 is execute. They need permission bit 0, 1 and 2 respectively. Kind 3 is reserved and always fails. A failed permission check gives trap code 4.
- R7: When several checks fail, the code reported is the first in the order range (1), invalid (2), limit (3), protection (4).
- R8: A request that passes every check gives `rsp_ok` high, `rsp_trap` equal to 0 and `rsp_pa` equal to base plus offset, modulo 2^PA_W.
- R9: Whenever `rsp_trap` is non-zero, `rsp_pa` is zero and `rsp_ok` is low.
- R10: A descriptor write or an in-use count write at the same edge as a request does not affect that request. It applies from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Descriptor write strobe |
| tbl_idx | input | SEG_W | Descriptor index to write |
| tbl_base | input | PA_W | Base physical address to write |
| tbl_limit | input | OFF_W+1 | Segment length to write |
| tbl_valid | input | 1 | Valid flag to write |
| tbl_perm | input | 3 | Rights to write: bit0 read, bit1 write, bit2 execute |
| cnt_we | input | 1 | In-use count write strobe |
| cnt_val | input | SEG_W+1 | New in-use count |
| req_vld | input | 1 | Translation request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_vld | output | 1 | Result present this cycle |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_pa | output | PA_W | Physical address, zero on a trap |
| rsp_trap | output | 3 | 0 none, 1 range, 2 invalid, 3 limit, 4 protection |

## Verification
The assertions assume that the inputs are stable and known at each rising edge. They also assume that every control input is driven every cycle, including while no request is present, because idle responses are checked to be zero. The bench changes every input only on the falling edge. It drives all strobes explicitly each cycle, with zero as the default when a cycle has no operation. Count values written by the random phase stay within 0 to the number of descriptors. This also covers counts equal to the table size, where every segment number is in range.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int PERM_W = 3;

    typedef enum logic [2:0] {
        TRAP_NONE    = 3'd0,
        TRAP_RANGE   = 3'd1,
        TRAP_INVALID = 3'd2,
        TRAP_LIMIT   = 3'd3,
        TRAP_PROT    = 3'd4
    } trap_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;
endpackage

// File: rtl/seg_table.sv
module seg_table import seg_xlate_pkg::*; #(
    parameter int SEG_W = 3,
    parameter int LIM_W = 9,
    parameter int PA_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [PA_W-1:0]   wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic              wr_valid,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic [PA_W-1:0]   rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output logic              rd_valid,
    output logic [PERM_W-1:0] rd_perm
);
    localparam int NSEG = 1 << SEG_W;

    typedef struct packed {
        logic [PA_W-1:0]   base;
        logic [LIM_W-1:0]  limit;
        logic              valid;
        logic [PERM_W-1:0] perm;
    } desc_t;

    desc_t desc_d [NSEG];
    desc_t desc_q [NSEG];

    always_comb begin
        for (int i = 0; i < NSEG; i++) begin
            desc_d[i] = desc_q[i];
            if (we && (wr_idx == SEG_W'(i))) begin
                desc_d[i].base  = wr_base;
                desc_d[i].limit = wr_limit;
                desc_d[i].valid = wr_valid;
                desc_d[i].perm  = wr_perm;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEG; i++) desc_q[i] <= '0;
        end else begin
            for (int i = 0; i < NSEG; i++) desc_q[i] <= desc_d[i];
        end
    end

    assign rd_base  = desc_q[rd_idx].base;
    assign rd_limit = desc_q[rd_idx].limit;
    assign rd_valid = desc_q[rd_idx].valid;
    assign rd_perm  = desc_q[rd_idx].perm;
endmodule

// File: rtl/seg_check.sv
module seg_check import seg_xlate_pkg::*; #(
    parameter int SEG_W = 3,
    parameter int OFF_W = 8,
    parameter int PA_W  = 12
) (
    input  logic [SEG_W:0]    in_use,
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        kind,
    input  logic [PA_W-1:0]   base,
    input  logic [OFF_W:0]    limit,
    input  logic              valid,
    input  logic [PERM_W-1:0] perm,
    output trap_e             trap,
    output logic [PA_W-1:0]   pa
);
    localparam int PAD_W = PA_W - OFF_W;

    logic in_range;
    logic in_bound;
    logic allowed;

    assign in_range = {1'b0, seg} < in_use;
    assign in_bound = {1'b0, off} < limit;

    always_comb begin
        case (acc_e'(kind))
            ACC_READ:  allowed = perm[0];
            ACC_WRITE: allowed = perm[1];
            ACC_EXEC:  allowed = perm[2];
            default:   allowed = 1'b0;
        endcase
    end

    // fixed priority: range, validity, bound, rights
    always_comb begin
        if (!in_range)      trap = TRAP_RANGE;
        else if (!valid)    trap = TRAP_INVALID;
        else if (!in_bound) trap = TRAP_LIMIT;
        else if (!allowed)  trap = TRAP_PROT;
        else                trap = TRAP_NONE;
    end

    assign pa = base + {{PAD_W{1'b0}}, off};
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate import seg_xlate_pkg::*; #(
    parameter int SEG_W = 3,
    parameter int OFF_W = 8,
    parameter int PA_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [SEG_W-1:0]  tbl_idx,
    input  logic [PA_W-1:0]   tbl_base,
    input  logic [OFF_W:0]    tbl_limit,
    input  logic              tbl_valid,
    input  logic [2:0]        tbl_perm,
    input  logic              cnt_we,
    input  logic [SEG_W:0]    cnt_val,
    input  logic              req_vld,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_kind,
    output logic              rsp_vld,
    output logic              rsp_ok,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [2:0]        rsp_trap
);
    localparam int LIM_W = OFF_W + 1;
    localparam int CNT_W = SEG_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             vld;
        logic             ok;
        logic [PA_W-1:0]  pa;
        logic [2:0]       trap;
    } state_t;

    state_t s_d, s_q;

    logic [PA_W-1:0]   ent_base;
    logic [LIM_W-1:0]  ent_limit;
    logic              ent_valid;
    logic [PERM_W-1:0] ent_perm;
    trap_e             chk_trap;
    logic [PA_W-1:0]   chk_pa;

    seg_table #(.SEG_W(SEG_W), .LIM_W(LIM_W), .PA_W(PA_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_base  (tbl_base),
        .wr_limit (tbl_limit),
        .wr_valid (tbl_valid),
        .wr_perm  (tbl_perm),
        .rd_idx   (req_seg),
        .rd_base  (ent_base),
        .rd_limit (ent_limit),
        .rd_valid (ent_valid),
        .rd_perm  (ent_perm)
    );

    seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_check (
        .in_use (s_q.cnt),
        .seg    (req_seg),
        .off    (req_off),
        .kind   (req_kind),
        .base   (ent_base),
        .limit  (ent_limit),
        .valid  (ent_valid),
        .perm   (ent_perm),
        .trap   (chk_trap),
        .pa     (chk_pa)
    );

    always_comb begin
        s_d = s_q;
        if (cnt_we) s_d.cnt = cnt_val;
        s_d.vld  = req_vld;
        s_d.ok   = req_vld && (chk_trap == TRAP_NONE);
        s_d.trap = req_vld ? chk_trap : TRAP_NONE;
        s_d.pa   = s_d.ok ? chk_pa : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_vld  = s_q.vld;
    assign rsp_ok   = s_q.ok;
    assign rsp_pa   = s_q.pa;
    assign rsp_trap = s_q.trap;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!rsp_vld && !rsp_ok && rsp_pa == '0 && rsp_trap == 3'd0)); // R2
    AST_RANGE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && ({1'b0, req_seg} >= s_q.cnt)) |=> (rsp_trap == 3'd1)); // R3
    AST_TRAP_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap != 3'd0) |-> (rsp_pa == '0 && !rsp_ok)); // R9
    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> (rsp_vld && rsp_trap == 3'd0)); // R8
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> $stable(s_q.cnt)); // R10
endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int SEG_W = 3;
    localparam int OFF_W = 8;
    localparam int PA_W  = 12;
    localparam int NSEG  = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic tbl_we = 0;
    logic [SEG_W-1:0] tbl_idx = '0;
    logic [PA_W-1:0] tbl_base = '0;
    logic [OFF_W:0] tbl_limit = '0;
    logic tbl_valid = 0;
    logic [2:0] tbl_perm = '0;
    logic cnt_we = 0;
    logic [SEG_W:0] cnt_val = '0;
    logic req_vld = 0;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic [1:0] req_kind = '0;
    logic rsp_vld, rsp_ok;
    logic [PA_W-1:0] rsp_pa;
    logic [2:0] rsp_trap;

    int total = 0;
    int bad = 0;

    int m_base [NSEG];
    int m_lim  [NSEG];
    int m_val  [NSEG];
    int m_perm [NSEG];
    int m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_seg_xlate (
        .clk(clk), .rst_n(rst_n),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_base(tbl_base),
        .tbl_limit(tbl_limit), .tbl_valid(tbl_valid), .tbl_perm(tbl_perm),
        .cnt_we(cnt_we), .cnt_val(cnt_val),
        .req_vld(req_vld), .req_seg(req_seg), .req_off(req_off), .req_kind(req_kind),
        .rsp_vld(rsp_vld), .rsp_ok(rsp_ok), .rsp_pa(rsp_pa), .rsp_trap(rsp_trap)
    );

    task automatic check_out(string tag, int ev, int eok, int epa, int etrap);
        total++;
        if (rsp_vld !== ev[0] || rsp_ok !== eok[0] || rsp_pa !== PA_W'(epa) || rsp_trap !== 3'(etrap)) begin
            bad++;
            $display("FAIL %s: got vld=%0d ok=%0d pa=%0h trap=%0d exp vld=%0d ok=%0d pa=%0h trap=%0d",
                     tag, rsp_vld, rsp_ok, rsp_pa, rsp_trap, ev, eok, epa, etrap);
        end
    endtask

    // one cycle: drive at falling edge, model before edge, compare after next falling edge
    task automatic cyc(string tag, int we, int idx, int base, int lim, int val, int perm,
                       int cwe, int cnt, int rv, int seg, int off, int kind);
        int etrap, eok, epa, allowed;
        tbl_we = we[0]; tbl_idx = SEG_W'(idx); tbl_base = PA_W'(base);
        tbl_limit = (OFF_W+1)'(lim); tbl_valid = val[0]; tbl_perm = 3'(perm);
        cnt_we = cwe[0]; cnt_val = (SEG_W+1)'(cnt);
        req_vld = rv[0]; req_seg = SEG_W'(seg); req_off = OFF_W'(off); req_kind = 2'(kind);
        etrap = 0; eok = 0; epa = 0;
        if (rv != 0) begin
            allowed = (kind == 0) ? (m_perm[seg] & 1) : (kind == 1) ? ((m_perm[seg] >> 1) & 1) :
                      (kind == 2) ? ((m_perm[seg] >> 2) & 1) : 0;
            if (seg >= m_cnt) etrap = 1;
            else if (m_val[seg] == 0) etrap = 2;
            else if (off >= m_lim[seg]) etrap = 3;
            else if (allowed == 0) etrap = 4;
            if (etrap == 0) begin
                eok = 1;
                epa = (m_base[seg] + off) % (1 << PA_W);
            end
        end
        @(posedge clk);
        if (we != 0) begin
            m_base[idx] = base; m_lim[idx] = lim; m_val[idx] = val; m_perm[idx] = perm;
        end
        if (cwe != 0) m_cnt = cnt;
        @(negedge clk);
        check_out(tag, rv, eok, epa, etrap);
    endtask

    task automatic wr(string tag, int idx, int base, int lim, int val, int perm);
        cyc(tag, 1, idx, base, lim, val, perm, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic rq(string tag, int seg, int off, int kind);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, seg, off, kind);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: got running exp finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSEG; i++) begin
            m_base[i] = 0; m_lim[i] = 0; m_val[i] = 0; m_perm[i] = 0;
        end
        repeat (3) @(negedge clk);
        check_out("R1 reset outputs", 0, 0, 0, 0);
        rst_n = 1;
        @(negedge clk);
        rq("R1 first request range trap", 0, 0, 0);
        cyc("R2 idle cycle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // count set together with a request: old count (0) still applies (R10)
        cyc("R10 count same cycle", 0, 0, 0, 0, 0, 0, 1, 4, 1, 0, 0, 0);
        // descriptor 1 written in same cycle as its use: old (invalid) entry used (R10)
        cyc("R10 write same cycle", 1, 1, 12'h100, 16, 1, 3'b011, 0, 0, 1, 1, 4, 0);
        rq("R10 next request sees write", 1, 4, 0);

        wr("R8 load 0", 0, 12'hFF0, 256, 1, 3'b111);
        wr("R4 load 2", 2, 12'h200, 32, 0, 3'b111);
        wr("R6 load 3", 3, 12'h300, 64, 1, 3'b100);

        rq("R8 wrap", 0, 8'h20, 0);
        rq("R8 plain", 0, 8'h05, 2);
        rq("R4 invalid", 2, 0, 0);
        rq("R5 off equals limit", 1, 16, 0);
        rq("R5 off limit minus one", 1, 15, 1);
        rq("R5 max offset full limit", 0, 255, 1);
        rq("R6 exec ok", 3, 1, 2);
        rq("R6 read denied", 3, 1, 0);
        rq("R6 write denied", 3, 1, 1);
        rq("R6 exec denied", 1, 1, 2);
        rq("R6 reserved kind", 0, 1, 3);
        rq("R3 seg equals count", 4, 0, 0);
        rq("R3 seg above count", 7, 0, 0);
        rq("R9 trap pa zero", 1, 200, 0);

        // priority
        wr("R7 load 5 invalid", 5, 0, 0, 0, 0);
        rq("R7 range over invalid", 5, 9, 3);
        rq("R7 invalid over limit", 2, 40, 3);
        rq("R7 limit over prot", 3, 70, 0);

        cyc("R3 count to full", 0, 0, 0, 0, 0, 0, 1, 8, 0, 0, 0, 0);
        rq("R4 seg5 now in range", 5, 0, 0);

        for (int n = 0; n < 400; n++) begin
            cyc("R8 random", ($urandom % 3) == 0, $urandom % NSEG, $urandom % 4096,
                $urandom % 300, ($urandom % 4) != 0, $urandom % 8,
                ($urandom % 10) == 0, $urandom % (NSEG + 1),
                ($urandom % 4) != 0, $urandom % NSEG, $urandom % 256, $urandom % 4);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule